// File: doc/BRIEF.md
# Selectable-Source Interrupt Timer

This block is an interrupt timer for a game cartridge controller. It holds an 8-bit prescaler and an 8-bit counter that count down together. The prescaler steps on every timer clock, and the counter steps each time the prescaler wraps. When the counter wraps while the timer is enabled, an active-high interrupt request is raised. That request stays up until software disables the timer.

The timer clock comes from one of four bus events, chosen by software. The choices are CPU clock cycles, rising edges of video address line 12, changes of the video address, and CPU writes to any address. An address change counts as two timer clocks. Values written into the prescaler and the counter are first XORed with a programmable key.

Eight write-only registers sit at consecutive offsets. The surrounding decoder supplies a register-write strobe and the offset. It also supplies a separate strobe for every CPU write and the raw event strobes.

Top module: `bus_event_irq_timer`

## Requirements
- R1: Reset clears the enable, source select, prescaler, counter, key and remembered video address to zero, and holds `irq` low.
- R2: A write at offset 0 sets the enable from data bit 0. When that bit is 0, the write also clears the prescaler and drops `irq`.
- R3: A write at offset 2 disables the timer, clears the prescaler and drops `irq`. A write at offset 3 enables the timer.
- R4: Offset 4 loads the prescaler with data XOR key, offset 5 loads the counter with data XOR key, and offset 6 loads the key. A write at offset 7 changes nothing.
- R5: Data bits [1:0] written at offset 1 select the clock source: 0 CPU cycle strobe, 1 address-line-12 rise strobe, 2 video address change, 3 CPU write strobe. Strobes of sources that are not selected have no effect.
- R6: Each timer clock decrements the prescaler. The counter decrements when the prescaler goes from 0x00 to 0xFF. `irq` is raised when the counter goes from 0x00 to 0xFF, which happens after exactly p+1+256·c clocks from prescaler p and counter c.
- R7: In source 2, a video address strobe whose address differs from the last strobed address gives two timer clocks. A repeat of the same address gives none. The last address is recorded on every strobe, whatever the source.
- R8: In source 3, every CPU write gives one timer clock, including writes to this block's own registers. That clock is applied before the register write takes effect.
- R9: Once raised, `irq` stays high until a disabling write at offset 0 or offset 2.
- R10: While the timer is disabled, timer clocks are ignored, and the prescaler and counter keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Strobe for any CPU write cycle |
| reg_wr | input | 1 | Strobe for a CPU write to this block's registers |
| reg_off | input | 3 | Register offset of the write |
| wr_data | input | 8 | Write data |
| cpu_cycle | input | 1 | CPU clock cycle strobe |
| a12_rise | input | 1 | Video address line 12 rising-edge strobe |
| ppu_addr_vld | input | 1 | Video address strobe |
| ppu_addr | input | 14 | Video address presented with the strobe |
| irq | output | 1 | Interrupt request, active high |

## Verification
The main check sweeps every clock source against prescaler values 0, 1, 0x80 and 0xFF, counter values 0 to 2, and two keys. For each case, the clock on which `irq` must rise is computed from p+1+256·c. The key sweep separates a correct XOR of the loads from a missing one. The sweep over p and c separates prescaler carries from counter carries. The address-change source checks that each change is counted twice. Odd totals overshoot by one clock. Directed patterns cover the rest. Strobes of unselected sources must not shorten the count. Strobes given while disabled must leave the count as it was. Disabling writes must clear the prescaler, which shows up as a one-clock interrupt afterwards. A register write in CPU-write mode must count as a clock.

// File: rtl/bus_event_irq_timer_pkg.sv
package bus_event_irq_timer_pkg;

    // Timer clock sources, encoded as written at offset 1 bits [1:0]
    typedef enum logic [1:0] {
        SRC_CPU_CYCLE = 2'd0,
        SRC_A12_RISE  = 2'd1,
        SRC_ADDR_CHG  = 2'd2,
        SRC_CPU_WRITE = 2'd3
    } clk_src_e;

    // Register offsets
    localparam logic [2:0] OFF_ENABLE    = 3'd0;
    localparam logic [2:0] OFF_SOURCE    = 3'd1;
    localparam logic [2:0] OFF_DISABLE   = 3'd2;
    localparam logic [2:0] OFF_ARM       = 3'd3;
    localparam logic [2:0] OFF_PRESCALE  = 3'd4;
    localparam logic [2:0] OFF_COUNT     = 3'd5;
    localparam logic [2:0] OFF_KEY       = 3'd6;

    // Timer clocks produced by one address-change event
    localparam int ADDR_CHG_TICKS = 2;
    // Most timer clocks any single cycle can carry
    localparam int MAX_TICKS      = ADDR_CHG_TICKS;
    localparam int TICK_W         = $clog2(MAX_TICKS + 1);

endpackage

// File: rtl/bus_event_irq_timer_event_sel.sv
module bus_event_irq_timer_event_sel
    import bus_event_irq_timer_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  clk_src_e          src,
    input  logic              cpu_cycle,
    input  logic              a12_rise,
    input  logic              cpu_wr,
    input  logic              ppu_addr_vld,
    input  logic [ADDR_W-1:0] ppu_addr,
    input  logic [ADDR_W-1:0] last_addr,
    output logic [TICK_W-1:0] n_ticks
);

    logic addr_moved;

    always_comb begin
        addr_moved = ppu_addr_vld && (ppu_addr != last_addr);
        n_ticks    = '0;
        unique case (src)
            SRC_CPU_CYCLE: n_ticks = cpu_cycle  ? TICK_W'(1) : '0;
            SRC_A12_RISE:  n_ticks = a12_rise   ? TICK_W'(1) : '0;
            SRC_ADDR_CHG:  n_ticks = addr_moved ? TICK_W'(ADDR_CHG_TICKS) : '0;
            SRC_CPU_WRITE: n_ticks = cpu_wr     ? TICK_W'(1) : '0;
            default:       n_ticks = '0;
        endcase
    end

endmodule

// File: rtl/bus_event_irq_timer_tick_stage.sv
module bus_event_irq_timer_tick_stage #(
    parameter int DATA_W = 8
) (
    input  logic              active,
    input  logic [DATA_W-1:0] pre_i,
    input  logic [DATA_W-1:0] cnt_i,
    input  logic              irq_i,
    output logic [DATA_W-1:0] pre_o,
    output logic [DATA_W-1:0] cnt_o,
    output logic              irq_o
);

    always_comb begin
        pre_o = pre_i;
        cnt_o = cnt_i;
        irq_o = irq_i;
        if (active) begin
            pre_o = pre_i - 1'b1;
            if (pre_i == '0) begin
                cnt_o = cnt_i - 1'b1;
                if (cnt_i == '0) begin
                    irq_o = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/bus_event_irq_timer.sv
module bus_event_irq_timer
    import bus_event_irq_timer_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic              reg_wr,
    input  logic [2:0]        reg_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cpu_cycle,
    input  logic              a12_rise,
    input  logic              ppu_addr_vld,
    input  logic [ADDR_W-1:0] ppu_addr,
    output logic              irq
);

    typedef struct packed {
        logic              en;
        clk_src_e          src;
        logic [DATA_W-1:0] pre;
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] key;
        logic [ADDR_W-1:0] last;
        logic              irq;
    } state_t;

    state_t s_d, s_q;

    logic [TICK_W-1:0] n_ticks;

    // Chain of decrement stages; index 0 is the registered state
    logic [DATA_W-1:0] pre_c [MAX_TICKS+1];
    logic [DATA_W-1:0] cnt_c [MAX_TICKS+1];
    logic              irq_c [MAX_TICKS+1];

    // Plain views of state for the bound checker
    logic              en_q;
    logic [1:0]        src_q;
    logic [DATA_W-1:0] pre_q;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] key_q;
    logic [ADDR_W-1:0] last_q;

    assign en_q   = s_q.en;
    assign src_q  = s_q.src;
    assign pre_q  = s_q.pre;
    assign cnt_q  = s_q.cnt;
    assign key_q  = s_q.key;
    assign last_q = s_q.last;

    bus_event_irq_timer_event_sel #(
        .ADDR_W(ADDR_W)
    ) u_event_sel (
        .src         (s_q.src),
        .cpu_cycle   (cpu_cycle),
        .a12_rise    (a12_rise),
        .cpu_wr      (cpu_wr),
        .ppu_addr_vld(ppu_addr_vld),
        .ppu_addr    (ppu_addr),
        .last_addr   (s_q.last),
        .n_ticks     (n_ticks)
    );

    assign pre_c[0] = s_q.pre;
    assign cnt_c[0] = s_q.cnt;
    assign irq_c[0] = s_q.irq;

    for (genvar g = 0; g < MAX_TICKS; g++) begin : g_tick
        logic stage_on;
        assign stage_on = s_q.en && (n_ticks > TICK_W'(g));
        bus_event_irq_timer_tick_stage #(
            .DATA_W(DATA_W)
        ) u_stage (
            .active(stage_on),
            .pre_i (pre_c[g]),
            .cnt_i (cnt_c[g]),
            .irq_i (irq_c[g]),
            .pre_o (pre_c[g+1]),
            .cnt_o (cnt_c[g+1]),
            .irq_o (irq_c[g+1])
        );
    end

    always_comb begin
        s_d     = s_q;
        // Timer clocks first, register effect second
        s_d.pre = pre_c[MAX_TICKS];
        s_d.cnt = cnt_c[MAX_TICKS];
        s_d.irq = irq_c[MAX_TICKS];
        if (ppu_addr_vld) begin
            s_d.last = ppu_addr;
        end
        if (reg_wr) begin
            unique case (reg_off)
                OFF_ENABLE: begin
                    s_d.en = wr_data[0];
                    if (!wr_data[0]) begin
                        s_d.pre = '0;
                        s_d.irq = 1'b0;
                    end
                end
                OFF_SOURCE:   s_d.src = clk_src_e'(wr_data[1:0]);
                OFF_DISABLE: begin
                    s_d.en  = 1'b0;
                    s_d.pre = '0;
                    s_d.irq = 1'b0;
                end
                OFF_ARM:      s_d.en  = 1'b1;
                OFF_PRESCALE: s_d.pre = wr_data ^ s_q.key;
                OFF_COUNT:    s_d.cnt = wr_data ^ s_q.key;
                OFF_KEY:      s_d.key = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{en: 1'b0, src: SRC_CPU_CYCLE, pre: '0, cnt: '0,
                     key: '0, last: '0, irq: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign irq = s_q.irq;

endmodule

// File: rtl/bus_event_irq_timer_chk.sv
module bus_event_irq_timer_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [2:0]        reg_off,
    input logic [DATA_W-1:0] wr_data,
    input logic              ppu_addr_vld,
    input logic [ADDR_W-1:0] ppu_addr,
    input logic              irq,
    input logic              en_q,
    input logic [1:0]        src_q,
    input logic [DATA_W-1:0] pre_q,
    input logic [DATA_W-1:0] cnt_q,
    input logic [DATA_W-1:0] key_q,
    input logic [ADDR_W-1:0] last_q
);

    logic dis_wr;
    assign dis_wr = reg_wr && ((reg_off == 3'd2) || (reg_off == 3'd0 && !wr_data[0]));

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!irq && !en_q && pre_q == '0 && cnt_q == '0 && key_q == '0));

    assert_off0_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_off == 3'd0 && !wr_data[0]) |=> (!irq && !en_q && pre_q == '0));

    assert_off2_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_off == 3'd2) |=> (!irq && !en_q && pre_q == '0));

    assert_key_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_off == 3'd6) |=> (key_q == $past(wr_data)));

    assert_pre_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_off == 3'd4) |=> (pre_q == ($past(wr_data) ^ $past(key_q))));

    assert_irq_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> en_q);

    assert_same_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && src_q == 2'd2 && ppu_addr_vld && ppu_addr == last_q && !reg_wr)
        |=> ($stable(pre_q) && $stable(cnt_q)));

    assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !dis_wr) |=> irq);

    assert_idle_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !(reg_wr && (reg_off == 3'd4 || reg_off == 3'd5 || dis_wr)))
        |=> ($stable(pre_q) && $stable(cnt_q) && !$rose(irq)));

endmodule

bind bus_event_irq_timer bus_event_irq_timer_chk #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_off     (reg_off),
    .wr_data     (wr_data),
    .ppu_addr_vld(ppu_addr_vld),
    .ppu_addr    (ppu_addr),
    .irq         (irq),
    .en_q        (en_q),
    .src_q       (src_q),
    .pre_q       (pre_q),
    .cnt_q       (cnt_q),
    .key_q       (key_q),
    .last_q      (last_q)
);

// File: tb/bus_event_irq_timer_bench.sv
module bus_event_irq_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_off = '0;
    logic [7:0]  wr_data = '0;
    logic        cpu_cycle = 1'b0;
    logic        a12_rise = 1'b0;
    logic        ppu_addr_vld = 1'b0;
    logic [13:0] ppu_addr = '0;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    int addr_ctr = 1;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bus_event_irq_timer u_bus_event_irq_timer (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .reg_wr(reg_wr),
        .reg_off(reg_off), .wr_data(wr_data), .cpu_cycle(cpu_cycle),
        .a12_rise(a12_rise), .ppu_addr_vld(ppu_addr_vld),
        .ppu_addr(ppu_addr), .irq(irq)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: irq actual %0b expected %0b", req, act, exp);
        end
    endtask

    // All stimulus changes at falling edges; sampling after the following fall
    task automatic wr(input logic [2:0] off, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; cpu_wr = 1'b1; reg_off = off; wr_data = d;
        @(negedge clk);
        reg_wr = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic pulse(input int src);
        @(negedge clk);
        case (src)
            0: cpu_cycle = 1'b1;
            1: a12_rise = 1'b1;
            2: begin
                ppu_addr_vld = 1'b1;
                ppu_addr = 14'(addr_ctr);
                addr_ctr++;
            end
            default: cpu_wr = 1'b1;
        endcase
        @(negedge clk);
        cpu_cycle = 1'b0; a12_rise = 1'b0; ppu_addr_vld = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic ppu_at(input logic [13:0] a);
        @(negedge clk);
        ppu_addr_vld = 1'b1; ppu_addr = a;
        @(negedge clk);
        ppu_addr_vld = 1'b0;
    endtask

    task automatic setup(input int src, input int p, input int c, input int key);
        wr(3'd2, 8'h00);
        wr(3'd6, 8'(key));
        wr(3'd1, 8'(src));
        wr(3'd4, 8'(p ^ key));
        wr(3'd5, 8'(c ^ key));
    endtask

    // Sweep case: irq must rise on the clock numbered p+1+256c (R6)
    task automatic run(input int src, input int p, input int c, input int key);
        int total;
        int events;
        total  = p + 1 + 256 * c;
        events = (src == 2) ? (total + 1) / 2 : total;
        setup(src, p, c, key);
        wr(3'd3, 8'h00);
        for (int k = 1; k < events; k++) pulse(src);
        check($sformatf("R6 src%0d p%0d c%0d key%0h before", src, p, c, key), irq, 1'b0);
        if (src == 3) wr(3'd7, 8'h5A);   // R8: a register write is itself a clock, R4 offset 7 inert
        else pulse(src);
        check($sformatf("R6 src%0d p%0d c%0d key%0h at", src, p, c, key), irq, 1'b1);
        pulse(src);
        check("R9 irq holds", irq, 1'b1);
        if (c == 1) wr(3'd0, 8'h00); else wr(3'd2, 8'h00);
        check("R2/R3 disable drops irq", irq, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset irq low", irq, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset irq low", irq, 1'b0);

        // R1/R7: last address reset to 0, same address gives no clocks
        wr(3'd1, 8'h02);
        wr(3'd3, 8'h00);
        ppu_at(14'd0);
        check("R1 R7 addr 0 equals reset last address", irq, 1'b0);
        ppu_at(14'd0);
        check("R7 repeated address no clock", irq, 1'b0);
        ppu_at(14'd5);
        check("R7 changed address clocks from zeroed timer", irq, 1'b1);
        wr(3'd2, 8'h00);

        // R5: unselected strobes ignored (source 1, needs 4 clocks)
        setup(1, 3, 0, 0);
        wr(3'd3, 8'h00);
        for (int k = 0; k < 10; k++) begin
            pulse(0); pulse(2); pulse(3);
        end
        for (int k = 0; k < 3; k++) pulse(1);
        check("R5 other sources ignored", irq, 1'b0);
        pulse(1);
        check("R5 selected source counts", irq, 1'b1);

        // R10: clocks while disabled are ignored; enable via offset 0 (R2)
        setup(0, 5, 0, 0);
        for (int k = 0; k < 20; k++) pulse(0);
        wr(3'd0, 8'h01);
        for (int k = 0; k < 5; k++) pulse(0);
        check("R10 disabled clocks ignored", irq, 1'b0);
        pulse(0);
        check("R10 count resumes intact", irq, 1'b1);

        // R2: offset 0 with bit0=0 clears the prescaler
        setup(0, 16, 0, 0);
        wr(3'd3, 8'h00);
        for (int k = 0; k < 3; k++) pulse(0);
        wr(3'd0, 8'h00);
        wr(3'd0, 8'h01);
        check("R2 irq low after re-enable", irq, 1'b0);
        pulse(0);
        check("R2 prescaler cleared", irq, 1'b1);

        // R3: offset 2 clears the prescaler, offset 3 re-enables
        setup(0, 16, 0, 0);
        wr(3'd3, 8'h00);
        for (int k = 0; k < 3; k++) pulse(0);
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h00);
        check("R3 irq low after re-enable", irq, 1'b0);
        pulse(0);
        check("R3 prescaler cleared", irq, 1'b1);
        wr(3'd2, 8'h00);

        // Sweep: every source, prescaler, counter and key (R4 R5 R6 R7 R8 R9)
        for (int s = 0; s < 4; s++)
            for (int pi = 0; pi < 4; pi++)
                for (int c = 0; c < 3; c++)
                    for (int ki = 0; ki < 2; ki++) begin
                        int p;
                        p = (pi == 0) ? 0 : (pi == 1) ? 1 : (pi == 2) ? 8'h80 : 8'hFF;
                        run(s, p, c, (ki == 0) ? 0 : 8'hA5);
                    end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule